// File: doc/BRIEF.md
# March C- Memory Self-Test Engine

This block tests a small synchronous single-port RAM on its own. After a one-cycle start request it drives the RAM's address, write data, write enable and read enable through the six march elements of the March C- algorithm. It reads each word and checks it against the value the algorithm predicts, then writes the opposite value back. It changes address direction between elements, so coupling and address-decoder faults show up as well as stuck and transition faults.

Two backgrounds are available: an all-zero solid pattern and a checkerboard whose polarity flips with address parity. An optional pause of a programmable length can be placed in front of every element that begins with a read, which screens for cells that lose their data over time. When the run ends the engine raises a one-cycle done strobe with a pass flag. If any word compared wrong, the address, element number, expected word and returned word of the first mismatch are held on the log outputs.

The RAM must return read data exactly one cycle after the read request. Address and data widths are parameters, and the RAM depth is 2^ADDR_W words.

Top module: `march_selftest`

## Requirements
- R1: After reset, done, pass, fail_valid, mem_we and mem_re are all low.
- R2: A start pulse while idle runs elements 0..5 in this order. Element 0 writes B. Element 1 reads B then writes ~B at each address. Element 2 reads ~B then writes B. Element 3 reads B then writes ~B. Element 4 reads ~B then writes B. Element 5 reads B. Elements 0, 1, 2 and 5 step addresses upward from 0. Elements 3 and 4 step downward from the top address.
- R3: Within elements 1 to 4, each read is followed in the next cycle by the write to the same address. mem_we and mem_re are never high in the same cycle.
- R4: With bg_checker low, B is all zeros. With bg_checker high, B at an even address has bit i set exactly when i is even (0x55 for 8 bits), and at an odd address it is the inverse.
- R5: A run with no pause issues exactly 10·2^ADDR_W memory operations, one per cycle. done is high for a single cycle, 10·2^ADDR_W+2 rising edges after the edge that samples start (that edge included). No operation is issued while done is high.
- R6: If pause_len = P is nonzero, P idle cycles precede each of elements 1 to 5. This lengthens the run by 5·P cycles and leaves the operation stream unchanged.
- R7: Read data is compared one cycle after its read. Any mismatch clears pass. pass is high while done is high only if no read mismatched.
- R8: On the first mismatch of a run, fail_valid rises and the log captures the address, the element number (0..5), the expected word and the returned word. Later mismatches leave the log unchanged.
- R9: A start pulse during a run is ignored. bg_checker and pause_len are sampled only at an accepted start.
- R10: An accepted start sets pass high and clears fail_valid, so results of an earlier run do not carry over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run request, accepted only when idle |
| bg_checker | input | 1 | 0 selects the solid background, 1 selects the checkerboard |
| pause_len | input | PAUSE_W | Idle cycles inserted before each read element (0 = none) |
| mem_addr | output | ADDR_W | RAM address |
| mem_wdata | output | DATA_W | RAM write data |
| mem_we | output | 1 | RAM write enable |
| mem_re | output | 1 | RAM read enable |
| mem_rdata | input | DATA_W | RAM read data, valid one cycle after mem_re |
| done | output | 1 | One-cycle end-of-run strobe |
| pass | output | 1 | High while no mismatch has been seen in the current run |
| fail_valid | output | 1 | A failure has been logged |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_elem | output | 3 | Element number of the first mismatch |
| fail_expect | output | DATA_W | Expected word at the first mismatch |
| fail_read | output | DATA_W | Returned word at the first mismatch |

## Verification
The properties assume that start is a plain request which may come at any time. They also assume the RAM behaves as an ideal one-cycle-latency model, although its read values may be faulty. The log-hold property assumes only that start stays low in the cycle under test. Relative to start, the bench raises start while idle, and in one scenario again part-way through a run. It drives a RAM model whose faults change only returned data, never timing, so every timing property stays valid even in runs that fail.

// File: rtl/march_selftest_pkg.sv
package march_selftest_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RUN,
      ST_PAUSE,
      ST_DRAIN,
      ST_FIN
   } mst_state_t;

   localparam int unsigned ELEM_W    = 3;
   localparam logic [2:0]  LAST_ELEM = 3'd5;

   // elements that walk from the top address down to zero
   function automatic logic elem_desc(input logic [2:0] e);
      return (e == 3'd3) || (e == 3'd4);
   endfunction

   function automatic logic elem_has_read(input logic [2:0] e);
      return e != 3'd0;
   endfunction

   function automatic logic elem_has_write(input logic [2:0] e);
      return e != LAST_ELEM;
   endfunction

   // read expects the complemented background
   function automatic logic elem_rd_inv(input logic [2:0] e);
      return (e == 3'd2) || (e == 3'd4);
   endfunction

   // write stores the complemented background
   function automatic logic elem_wr_inv(input logic [2:0] e);
      return (e == 3'd1) || (e == 3'd3);
   endfunction

endpackage

// File: rtl/march_addr_seq.sv
module march_addr_seq #(
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              load_desc,
   input  logic              step,
   output logic [ADDR_W-1:0] addr,
   output logic              at_end
);
   localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

   logic dir_down;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr     <= '0;
         dir_down <= 1'b0;
      end else if (load) begin
         addr     <= load_desc ? TOP_ADDR : '0;
         dir_down <= load_desc;
      end else if (step) begin
         addr <= dir_down ? addr - 1'b1 : addr + 1'b1;
      end
   end

   assign at_end = dir_down ? (addr == '0) : (addr == TOP_ADDR);
endmodule

// File: rtl/march_bg_gen.sv
module march_bg_gen #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              checker_en,
   input  logic              addr_lsb,
   input  logic              invert,
   output logic [DATA_W-1:0] word
);
   logic [DATA_W-1:0] chk_even;
   logic [DATA_W-1:0] base;

   for (genvar i = 0; i < DATA_W; i++) begin : g_chk_bit
      if ((i % 2) == 0) begin : g_one
         assign chk_even[i] = 1'b1;
      end else begin : g_zero
         assign chk_even[i] = 1'b0;
      end
   end

   always_comb begin
      if (checker_en) base = addr_lsb ? ~chk_even : chk_even;
      else            base = '0;
      word = invert ? ~base : base;
   end
endmodule

// File: rtl/march_resp.sv
module march_resp #(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              rd_issue,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [2:0]        rd_elem,
   input  logic [DATA_W-1:0] rd_expect,
   input  logic [DATA_W-1:0] rdata,
   output logic              pass,
   output logic              fail_valid,
   output logic [ADDR_W-1:0] fail_addr,
   output logic [2:0]        fail_elem,
   output logic [DATA_W-1:0] fail_expect,
   output logic [DATA_W-1:0] fail_read
);
   logic              pend;
   logic [ADDR_W-1:0] p_addr;
   logic [2:0]        p_elem;
   logic [DATA_W-1:0] p_exp;
   logic              miss;

   assign miss = pend && (rdata != p_exp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend   <= 1'b0;
         p_addr <= '0;
         p_elem <= '0;
         p_exp  <= '0;
      end else begin
         pend <= rd_issue;
         if (rd_issue) begin
            p_addr <= rd_addr;
            p_elem <= rd_elem;
            p_exp  <= rd_expect;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pass        <= 1'b0;
         fail_valid  <= 1'b0;
         fail_addr   <= '0;
         fail_elem   <= '0;
         fail_expect <= '0;
         fail_read   <= '0;
      end else if (clear) begin
         pass        <= 1'b1;
         fail_valid  <= 1'b0;
         fail_addr   <= '0;
         fail_elem   <= '0;
         fail_expect <= '0;
         fail_read   <= '0;
      end else if (miss) begin
         pass <= 1'b0;
         if (!fail_valid) begin
            fail_valid  <= 1'b1;
            fail_addr   <= p_addr;
            fail_elem   <= p_elem;
            fail_expect <= p_exp;
            fail_read   <= rdata;
         end
      end
   end
endmodule

// File: rtl/march_selftest.sv
module march_selftest
   import march_selftest_pkg::*;
#(
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned PAUSE_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               bg_checker,
   input  logic [PAUSE_W-1:0] pause_len,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [DATA_W-1:0]  mem_wdata,
   output logic               mem_we,
   output logic               mem_re,
   input  logic [DATA_W-1:0]  mem_rdata,
   output logic               done,
   output logic               pass,
   output logic               fail_valid,
   output logic [ADDR_W-1:0]  fail_addr,
   output logic [2:0]         fail_elem,
   output logic [DATA_W-1:0]  fail_expect,
   output logic [DATA_W-1:0]  fail_read
);
   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr_w
      $error("march_selftest: ADDR_W must lie in 1..16");
   end
   if (DATA_W < 2) begin : g_bad_data_w
      $error("march_selftest: DATA_W must be at least 2");
   end
   if (PAUSE_W < 1) begin : g_bad_pause_w
      $error("march_selftest: PAUSE_W must be at least 1");
   end

   mst_state_t         st;
   logic [2:0]         elem;
   logic               ph_wr;
   logic [PAUSE_W-1:0] pcnt;
   logic [PAUSE_W-1:0] pause_r;
   logic               bg_r;

   logic              start_ok;
   logic              is_rd, is_wr;
   logic              elem_end, run_end;
   logic              a_load, a_desc, a_step, at_end;
   logic              pat_inv;
   logic [ADDR_W-1:0] addr;
   logic [DATA_W-1:0] pat_word;

   always_comb begin
      start_ok = (st == ST_IDLE) && start;
      is_rd    = (st == ST_RUN) && elem_has_read(elem) && !ph_wr;
      is_wr    = (st == ST_RUN) && elem_has_write(elem) &&
                 (ph_wr || !elem_has_read(elem));
      elem_end = is_wr && at_end;
      run_end  = is_rd && !elem_has_write(elem) && at_end;
      a_load   = start_ok || elem_end;
      a_desc   = start_ok ? 1'b0 : elem_desc(elem + 3'd1);
      a_step   = (is_wr || (is_rd && !elem_has_write(elem))) && !at_end;
      pat_inv  = is_rd ? elem_rd_inv(elem) : elem_wr_inv(elem);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         elem    <= '0;
         ph_wr   <= 1'b0;
         pcnt    <= '0;
         pause_r <= '0;
         bg_r    <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (start) begin
                  st      <= ST_RUN;
                  elem    <= '0;
                  ph_wr   <= 1'b0;
                  bg_r    <= bg_checker;
                  pause_r <= pause_len;
               end
            end
            ST_RUN: begin
               if (is_rd && elem_has_write(elem)) ph_wr <= 1'b1;
               else if (is_wr)                    ph_wr <= 1'b0;
               if (elem_end) begin
                  elem <= elem + 3'd1;
                  pcnt <= '0;
                  st   <= (pause_r != '0) ? ST_PAUSE : ST_RUN;
               end else if (run_end) begin
                  st <= ST_DRAIN;
               end
            end
            ST_PAUSE: begin
               pcnt <= pcnt + 1'b1;
               if (pcnt == pause_r - 1'b1) st <= ST_RUN;
            end
            ST_DRAIN: st <= ST_FIN;
            default:  st <= ST_IDLE;
         endcase
      end
   end

   march_addr_seq #(.ADDR_W(ADDR_W)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (a_load),
      .load_desc (a_desc),
      .step      (a_step),
      .addr      (addr),
      .at_end    (at_end)
   );

   march_bg_gen #(.DATA_W(DATA_W)) u_bg (
      .checker_en (bg_r),
      .addr_lsb   (addr[0]),
      .invert     (pat_inv),
      .word       (pat_word)
   );

   march_resp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_resp (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear       (start_ok),
      .rd_issue    (is_rd),
      .rd_addr     (addr),
      .rd_elem     (elem),
      .rd_expect   (pat_word),
      .rdata       (mem_rdata),
      .pass        (pass),
      .fail_valid  (fail_valid),
      .fail_addr   (fail_addr),
      .fail_elem   (fail_elem),
      .fail_expect (fail_expect),
      .fail_read   (fail_read)
   );

   assign mem_addr  = addr;
   assign mem_wdata = pat_word;
   assign mem_we    = is_wr;
   assign mem_re    = is_rd;
   assign done      = (st == ST_FIN);
endmodule

// File: rtl/march_selftest_chk.sv
module march_selftest_chk #(
   parameter int unsigned ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              mem_we,
   input logic              mem_re,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              done,
   input logic              pass,
   input logic              fail_valid,
   input logic [ADDR_W-1:0] fail_addr
);
   assert_single_port_op_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));

   assert_write_follows_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(mem_re)) |-> (mem_addr == $past(mem_addr)));

   assert_done_single_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_quiet_at_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!mem_we && !mem_re));

   assert_pass_matches_log_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (pass == !fail_valid));

   assert_log_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fail_valid && !start) |=> (fail_valid && $stable(fail_addr)));
endmodule

bind march_selftest march_selftest_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .mem_we     (mem_we),
   .mem_re     (mem_re),
   .mem_addr   (mem_addr),
   .done       (done),
   .pass       (pass),
   .fail_valid (fail_valid),
   .fail_addr  (fail_addr)
);

// File: tb/march_selftest_bench.sv
module march_selftest_bench;
   localparam int AW = 4;
   localparam int DW = 8;
   localparam int PW = 4;
   localparam int N  = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          bg_checker = 1'b0;
   logic [PW-1:0] pause_len = '0;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic          mem_we, mem_re;
   logic [DW-1:0] mem_rdata;
   logic          done, pass, fail_valid;
   logic [AW-1:0] fail_addr;
   logic [2:0]    fail_elem;
   logic [DW-1:0] fail_expect, fail_read;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   march_selftest #(.ADDR_W(AW), .DATA_W(DW), .PAUSE_W(PW)) u_march_selftest (
      .clk (clk), .rst_n (rst_n), .start (start), .bg_checker (bg_checker),
      .pause_len (pause_len), .mem_addr (mem_addr), .mem_wdata (mem_wdata),
      .mem_we (mem_we), .mem_re (mem_re), .mem_rdata (mem_rdata),
      .done (done), .pass (pass), .fail_valid (fail_valid),
      .fail_addr (fail_addr), .fail_elem (fail_elem),
      .fail_expect (fail_expect), .fail_read (fail_read)
   );

   // RAM model with a per-address read fault (bits forced high / low)
   logic [DW-1:0] ram [N];
   logic [AW-1:0] f_addr = '0;
   logic [DW-1:0] f_set = '0;
   logic [DW-1:0] f_clr = '0;

   always_ff @(posedge clk) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      if (mem_re)
         mem_rdata <= (mem_addr == f_addr) ? ((ram[mem_addr] & ~f_clr) | f_set)
                                           : ram[mem_addr];
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] bgw(input bit chk, input int a, input bit inv);
      logic [DW-1:0] w;
      for (int i = 0; i < DW; i++) w[i] = ((i % 2) == 0) ^ ((a % 2) == 1);
      if (!chk) w = '0;
      return inv ? ~w : w;
   endfunction

   task automatic exp_op(input int k, input bit chk, output bit rd, output int a,
                         output logic [DW-1:0] d);
      int e, pos, j;
      bit inv;
      if (k < N) begin
         e = 0; rd = 0; pos = k;
      end else if (k < 9 * N) begin
         j   = k - N;
         e   = 1 + j / (2 * N);
         rd  = ((j % (2 * N)) % 2) == 0;
         pos = (j % (2 * N)) / 2;
      end else begin
         e = 5; rd = 1; pos = k - 9 * N;
      end
      a   = (e == 3 || e == 4) ? N - 1 - pos : pos;
      inv = rd ? (e == 2 || e == 4) : (e == 1 || e == 3);
      d   = bgw(chk, a, inv);
   endtask

   // runs one test; lat = rising edges from the start-sampling edge to done
   task automatic run_march(input bit chk, input int p, input bit disturb,
                            output int lat, output int op_err, output int nops,
                            output bit early_pass, output bit early_fv);
      bit rd;
      int a;
      logic [DW-1:0] d;
      @(negedge clk);
      bg_checker = chk;
      pause_len  = PW'(p);
      start      = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start  = 1'b0;
      lat    = 1;
      op_err = 0;
      nops   = 0;
      early_pass = pass;
      early_fv   = fail_valid;
      while (!done && lat < 4000) begin
         if (mem_we || mem_re) begin
            exp_op(nops, chk, rd, a, d);
            if (mem_re != rd || mem_we == rd || int'(mem_addr) != a ||
                (mem_we && mem_wdata != d)) op_err++;
            nops++;
         end
         if (disturb && lat == 7) begin
            start = 1'b1; bg_checker = ~chk; pause_len = PW'(5);
         end
         if (disturb && lat == 8) start = 1'b0;
         @(posedge clk);
         @(negedge clk);
         lat++;
      end
      if (mem_we || mem_re) op_err++;
   endtask

   task automatic t_reset();
      check(!done,       "R1", "done after reset",       32'(done), 0);
      check(!pass,       "R1", "pass after reset",       32'(pass), 0);
      check(!fail_valid, "R1", "fail_valid after reset", 32'(fail_valid), 0);
      check(!mem_we && !mem_re, "R1", "memory strobes after reset",
            32'({mem_we, mem_re}), 0);
   endtask

   task automatic t_clean(input bit chk, input int p);
      int lat, op_err, nops, bad;
      bit ep, ef;
      run_march(chk, p, 0, lat, op_err, nops, ep, ef);
      check(op_err == 0, "R2", "operation stream mismatches", op_err, 0);
      check(nops == 10 * N, "R5", "operation count", nops, 10 * N);
      if (p == 0) check(lat == 10 * N + 2, "R5", "done latency", lat, 10 * N + 2);
      else check(lat == 10 * N + 2 + 5 * p, "R6", "done latency with pause",
                 lat, 10 * N + 2 + 5 * p);
      check(ep && !ef, "R10", "pass/fail_valid just after start",
            32'({ep, ef}), 32'b10);
      check(pass && !fail_valid, "R7", "clean run result",
            32'({pass, fail_valid}), 32'b10);
      bad = 0;
      for (int i = 0; i < N; i++) if (ram[i] != bgw(chk, i, 0)) bad++;
      check(bad == 0, "R4", "final memory words not equal to background", bad, 0);
      @(negedge clk);
      check(!done, "R5", "done after one cycle", 32'(done), 0);
   endtask

   task automatic t_fault(input bit chk, input int fa, input logic [DW-1:0] fs,
                          input logic [DW-1:0] fc, input int e_elem,
                          input logic [DW-1:0] e_exp, input logic [DW-1:0] e_got);
      int lat, op_err, nops;
      bit ep, ef;
      f_addr = AW'(fa); f_set = fs; f_clr = fc;
      run_march(chk, 0, 0, lat, op_err, nops, ep, ef);
      check(op_err == 0, "R2", "operation stream under fault", op_err, 0);
      check(!pass, "R7", "pass after miscompare", 32'(pass), 0);
      check(fail_valid, "R8", "fail_valid", 32'(fail_valid), 1);
      check(int'(fail_addr) == fa, "R8", "fail_addr", 32'(fail_addr), 32'(fa));
      check(int'(fail_elem) == e_elem, "R8", "fail_elem", 32'(fail_elem), 32'(e_elem));
      check(fail_expect == e_exp, "R8", "fail_expect", 32'(fail_expect), 32'(e_exp));
      check(fail_read == e_got, "R8", "fail_read", 32'(fail_read), 32'(e_got));
      f_set = '0; f_clr = '0;
   endtask

   task automatic t_busy_start();
      int lat, op_err, nops, extra;
      bit ep, ef;
      run_march(1'b0, 0, 1, lat, op_err, nops, ep, ef);
      check(lat == 10 * N + 2, "R9", "latency with start during run", lat, 10 * N + 2);
      check(op_err == 0, "R9", "stream kept sampled background", op_err, 0);
      check(pass, "R9", "pass after ignored start", 32'(pass), 1);
      extra = 0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         if (done || mem_we || mem_re) extra++;
      end
      check(extra == 0, "R9", "activity after done", extra, 0);
      bg_checker = 1'b0; pause_len = '0;
   endtask

   initial begin
      #(8 * 100000);
      errors++;
      $display("FAIL R5 watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_clean(1'b0, 0);                                     // R2 R4 R5 solid
      t_clean(1'b1, 0);                                     // R2 R4 R5 checkerboard
      t_fault(1'b0, 5, 8'h04, 8'h00, 1, 8'h00, 8'h04);      // R8 first of several
      t_fault(1'b1, 3, 8'h00, 8'h01, 2, 8'h55, 8'h54);      // R8 complement read
      t_clean(1'b0, 0);                                     // R10 log cleared
      t_clean(1'b1, 3);                                     // R6 pause
      t_busy_start();                                       // R9
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule